// File: doc/BRIEF.md
# Address-Encoded Bit Set/Clear Output Port

This block keeps a bank of latched output bits that a processor changes one at a time without supplying any data. Every write strobe names a single bit through a 3-bit index field in the address and gives the value to store through the lowest address bit. Each output bit therefore has two addresses of its own, one that turns it on and one that turns it off. A store instruction to one of these addresses is enough to change the bit, and the register used by that instruction can hold any value.

Decoding of the upper address bits is done outside the block and reaches it as `wr_stb`, which is already qualified by the bus phase. Updates take effect on the rising clock edge where the strobe is high. The port has no streaming data path, so it uses no valid/ready handshake. The strobe and the readback are plain control and status pins with no back-pressure. A combinational readback output returns the bit that the current index field selects.

Top module: `bitset_port`

## Requirements
- R1: A high `rst` at a rising edge clears all eight `out_bits` to 0 at that edge.
- R2: A strobe with `addr[0]`=1 sets bit `addr[6:4]` of `out_bits` at that edge (for example, offset 0x51 sets bit 5).
- R3: A strobe with `addr[0]`=0 clears bit `addr[6:4]` of `out_bits` at that edge (for example, offset 0x00 clears bit 0).
- R4: On a strobe, every bit other than the indexed one keeps its value.
- R5: The value of `wdata` has no effect on `out_bits`.
- R6: With `wr_stb` low, `out_bits` holds its value.
- R7: When `rst` and `wr_stb` are both high at the same edge, reset wins and all bits become 0.
- R8: `rd_bit` equals `out_bits[addr[6:4]]` in the same cycle, without a clock. During a write cycle it shows the value from before the update.
- R9: A strobe held for several cycles at one address gives the same result as a single-cycle strobe.
- R10: Address bits 1 to 3 and bit 7 have no effect on which bit is updated or on the value stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; updates occur on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Phase-qualified write strobe for this port |
| addr | input | 8 | Low address bits: [6:4] bit index, [0] value to store |
| wdata | input | 8 | Processor data bus; not used by the update |
| out_bits | output | 8 | Latched output bits |
| rd_bit | output | 1 | Readback of the bit selected by addr[6:4] |

## Verification
The reset and the write strobe can arrive at the same edge. The bench drives both high in one cycle while the address asks to set a bit, and expects `out_bits` to be zero after that edge. A write and a readback can also fall in the same cycle. The bench samples `rd_bit` while the strobe is high, expects the value from before the update, and then expects the new value after the edge. Random set and clear sequences with random `wdata` are compared against a model in the bench, which catches any change to a bit the write did not address.

// File: rtl/bitset_port_pkg.sv
package bitset_port_pkg;
  localparam int unsigned NUM_BITS_DEF = 8;
  localparam int unsigned ADDR_W_DEF   = 8;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned IDX_LSB_DEF  = 4;
  localparam int unsigned VAL_BIT_DEF  = 0;

  typedef struct packed {
    logic       hit;
    logic       value;
  } bit_cmd_t;
endpackage

// File: rtl/bitset_decode.sv
module bitset_decode
  import bitset_port_pkg::*;
#(
  parameter int unsigned NUM_BITS = NUM_BITS_DEF,
  parameter int unsigned IDX_W    = $clog2(NUM_BITS),
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned IDX_LSB  = IDX_LSB_DEF,
  parameter int unsigned VAL_BIT  = VAL_BIT_DEF
) (
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   addr,
  output logic [IDX_W-1:0]    idx,
  output bit_cmd_t            cmd [NUM_BITS]
);
  assign idx = addr[IDX_LSB +: IDX_W];

  for (genvar g = 0; g < NUM_BITS; g++) begin : g_cmd
    always_comb begin
      cmd[g].hit   = wr_stb && (idx == IDX_W'(g));
      cmd[g].value = addr[VAL_BIT];
    end
  end
endmodule

// File: rtl/bitset_cell.sv
module bitset_cell
  import bitset_port_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bit_cmd_t cmd,
  output logic     q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= 1'b0;
    else if (cmd.hit) q <= cmd.value;
  end
endmodule

// File: rtl/bitset_readmux.sv
module bitset_readmux #(
  parameter int unsigned NUM_BITS = 8,
  parameter int unsigned IDX_W    = $clog2(NUM_BITS)
) (
  input  logic [NUM_BITS-1:0] bits,
  input  logic [IDX_W-1:0]    idx,
  output logic                bit_o
);
  assign bit_o = bits[idx];
endmodule

// File: rtl/bitset_port.sv
module bitset_port
  import bitset_port_pkg::*;
#(
  parameter int unsigned NUM_BITS = NUM_BITS_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned DATA_W   = DATA_W_DEF,
  parameter int unsigned IDX_LSB  = IDX_LSB_DEF,
  parameter int unsigned VAL_BIT  = VAL_BIT_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_BITS-1:0] out_bits,
  output logic                rd_bit
);
  localparam int unsigned IDX_W = $clog2(NUM_BITS);

  logic [IDX_W-1:0] idx;
  bit_cmd_t         cmd [NUM_BITS];

  bitset_decode #(
    .NUM_BITS(NUM_BITS), .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .IDX_LSB(IDX_LSB), .VAL_BIT(VAL_BIT)
  ) u_dec (
    .wr_stb(wr_stb), .addr(addr), .idx(idx), .cmd(cmd)
  );

  for (genvar g = 0; g < NUM_BITS; g++) begin : g_bit
    bitset_cell u_cell (
      .clk(clk), .rst(rst), .cmd(cmd[g]), .q(out_bits[g])
    );
  end

  bitset_readmux #(.NUM_BITS(NUM_BITS), .IDX_W(IDX_W)) u_rd (
    .bits(out_bits), .idx(idx), .bit_o(rd_bit)
  );
endmodule

// File: rtl/bitset_port_chk.sv
module bitset_port_chk #(
  parameter int unsigned NUM_BITS = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IDX_LSB  = 4,
  parameter int unsigned VAL_BIT  = 0
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_stb,
  input logic [ADDR_W-1:0]   addr,
  input logic [DATA_W-1:0]   wdata,
  input logic [NUM_BITS-1:0] out_bits,
  input logic                rd_bit
);
  localparam int unsigned IDX_W = $clog2(NUM_BITS);

  logic [IDX_W-1:0]    sel;
  logic [NUM_BITS-1:0] sel_mask;
  assign sel      = addr[IDX_LSB +: IDX_W];
  assign sel_mask = NUM_BITS'(1) << sel;

  // R1, R7: reset, even with a strobe, gives all zeros
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (out_bits == '0));

  // R2, R3: addressed bit takes the value bit of the address
  assert_bit_takes_value_R2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (out_bits[$past(sel)] == $past(addr[VAL_BIT])));

  // R4: no other bit moves on a write
  assert_others_kept_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (((out_bits ^ $past(out_bits)) & ~$past(sel_mask)) == '0));

  // R6: no strobe, no change
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(out_bits));

  // R5, R9: a repeated write to the same address with other data changes nothing
  assert_repeat_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && $past(wr_stb) && !$past(rst) && (addr == $past(addr)) &&
     (wdata != $past(wdata))) |=> $stable(out_bits));

  // R8: readback follows the selected output
  always_comb begin
    if (!rst) assert_readback_R8: assert (rd_bit == out_bits[sel]);
  end
endmodule

bind bitset_port bitset_port_chk #(
  .NUM_BITS(NUM_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .IDX_LSB(IDX_LSB), .VAL_BIT(VAL_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
  .out_bits(out_bits), .rd_bit(rd_bit)
);

// File: tb/tb_bitset_port.sv
`timescale 1ns/1ps
module tb_bitset_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] out_bits;
  logic       rd_bit;

  int checks = 0;
  int errors = 0;
  logic [7:0] model;

  always #2.5 clk = ~clk;

  bitset_port dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
    .out_bits(out_bits), .rd_bit(rd_bit)
  );

  // {addr, wdata, expected out_bits}, applied in order from all-zero
  localparam logic [23:0] VEC [10] = '{
    {8'h51, 8'hA5, 8'h20},  // R2 set bit 5
    {8'h61, 8'h00, 8'h60},  // R2 set bit 6, R4
    {8'h01, 8'h3C, 8'h61},  // R2 set bit 0
    {8'h71, 8'h00, 8'hE1},  // R2 set bit 7
    {8'h50, 8'hFF, 8'hC1},  // R3 clear bit 5, R5 data all ones
    {8'h00, 8'h01, 8'hC0},  // R3 clear bit 0
    {8'h31, 8'h00, 8'hC8},  // R2 set bit 3
    {8'h1F, 8'h00, 8'hCA},  // R10 bits 1..3 high, set bit 1
    {8'hE0, 8'hFF, 8'h8A},  // R10 bit 7 high, clear bit 6
    {8'h41, 8'h55, 8'h9A}   // R2 set bit 4
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", out_bits, 8'h00);

    for (int i = 0; i < 10; i++) begin
      do_write(VEC[i][23:16], VEC[i][15:8]);
      check("R2/R3/R4/R5/R10 vector", out_bits, VEC[i][7:0]);
    end

    // R6: idle cycles with address and data moving
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      addr = 8'(i * 37 + 1); wdata = 8'(i * 11);
    end
    @(negedge clk);
    check("R6 hold while idle", out_bits, 8'h9A);

    // R8: readback same cycle shows old value, then new value
    @(negedge clk);
    addr = 8'h21; wdata = 8'h00; wr_stb = 1'b1;
    #1;
    check("R8 readback before update", {7'b0, rd_bit}, 8'h00);
    @(negedge clk);
    wr_stb = 1'b0;
    #1;
    check("R8 readback after update", {7'b0, rd_bit}, 8'h01);
    check("R2 bit 2 set", out_bits, 8'h9E);
    addr = 8'h70; #1;
    check("R8 readback bit 7", {7'b0, rd_bit}, 8'h01);

    // R9: strobe held four cycles with changing data
    @(negedge clk);
    addr = 8'h70; wr_stb = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wdata = 8'(i * 85);
      @(negedge clk);
    end
    wr_stb = 1'b0;
    check("R9 held strobe clear bit 7", out_bits, 8'h1E);

    // R7: reset and strobe together
    @(negedge clk);
    addr = 8'h71; wr_stb = 1'b1; rst = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; rst = 1'b0;
    check("R7 reset beats strobe", out_bits, 8'h00);

    // R4/R5: random sequence against a model
    model = 8'h00;
    for (int i = 0; i < 200; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      do_write(a, 8'($urandom));
      model[a[6:4]] = a[0];
      check("R4 random sequence", out_bits, model);
    end

    // R1: reset after activity
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset after activity", out_bits, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule